// File: doc/BRIEF.md
# Receive Packet Deframer

This block sits behind a clock and data recovery stage and turns a stream of recovered bits into stored packets. It hunts for a run of alternating bits that marks the start of a frame, then looks for a programmable synchronisation word while tolerating a set number of bit errors. Once synchronised, it undoes the line coding chosen by configuration (none, Manchester or PN9 whitening), assembles bytes most significant bit first, and writes them into a packet buffer through a simple byte-write port.

The first decoded byte carries the frame length and the second a destination address. A bad length or a foreign address ends the frame at once, so the buffer is not filled with traffic meant for another node. After the payload, a 16-bit CRC is checked. Every step that succeeds (or the CRC verdict) sets its own sticky bit in an event status register. Each bit can be enabled toward a single interrupt line and cleared by a masked write.

Top module: `rxdf_deframer`

## Requirements
- R1: Preamble detection fires when the count of consecutive alternating bits reaches the effective preamble length, which is `cfg_pre_len` clamped to the range 8 to 32. It sets status bit 0 and starts the sync search. A shorter run sets nothing.
- R2: In sync search, every accepted bit forms a 16-bit window with the newest bit at bit 0. The window matches when it differs from `cfg_sync` in no more than `cfg_sync_tol` (0 to 3) bit positions. A match sets status bit 1, and the payload starts with the next bit.
- R3: Everything after the sync word, CRC included, is decoded by `cfg_code`. Code 0 and code 3 pass bits through unchanged. Code 1 is Manchester: chip pair 10 gives 1 and 01 gives 0, with pairing starting at the first chip after sync. Code 2 XORs each bit with bit 0 of a 9-bit register seeded to 0x1FF at sync. After each bit that register shifts right and takes bit0 XOR bit5 into bit 8.
- R4: A Manchester chip pair of 00 or 11 aborts the frame. Nothing further is written, no CRC bit is set, and the block returns to preamble search.
- R5: The first decoded byte is the length L. L from 1 to 240 is written at buffer address 0. L of 0 or above 240 aborts with no write at all.
- R6: The second byte is written at address 1. If it equals `cfg_addr`, status bit 2 is set and the L-1 data bytes are written at addresses 2 to L. Otherwise the frame is dropped: no further write, no bit 2, no CRC bit.
- R7: The two bytes after the data are a CRC-16 sent most significant byte first. It uses polynomial 0x1021 and initial value 0xFFFF, and covers the length, address and data bits in order. These bytes are not written. A match sets status bit 3 and a mismatch sets status bit 4, and the block then returns to preamble search.
- R8: Status bits are sticky. A cycle with `st_clr` high clears the bits set in `st_clr_mask`. An event in the same cycle wins over the clear.
- R9: `irq` is high when any status bit is set together with its `irq_en` bit. Status bits record events even when their enable is low.
- R10: After reset, the status is 0, `irq` is low, and no buffer write occurs.
- R11: Cycles with `bit_vld` low carry no bit and do not affect detection, decoding or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | A recovered bit is present this cycle |
| bit_in | input | 1 | Recovered bit value |
| cfg_pre_len | input | 6 | Required alternating run length (clamped 8..32) |
| cfg_sync | input | 16 | Sync word, first received bit at bit 15 |
| cfg_sync_tol | input | 2 | Allowed sync bit errors |
| cfg_code | input | 2 | Line decoding: 0 raw, 1 Manchester, 2 whitening, 3 raw |
| cfg_addr | input | 8 | Own node address |
| irq_en | input | 5 | Per-event interrupt enables |
| st_clr | input | 1 | Status clear strobe |
| st_clr_mask | input | 5 | Status bits to clear |
| buf_we | output | 1 | Packet buffer byte write |
| buf_addr | output | 8 | Packet buffer byte address |
| buf_data | output | 8 | Packet buffer byte data |
| irq_status | output | 5 | Event status: 0 preamble, 1 sync, 2 address, 3 CRC good, 4 CRC bad |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a preamble one bit shorter than the clamped minimum, which a design without clamping or with an off-by-one run counter would wrongly flag. It sends sync words with exactly the tolerated number of errors and one more than tolerated, so a wrong comparison threshold shows up as a missing or extra sync event. Frames with a foreign address, a zero or oversize length, a Manchester violation and a corrupted CRC check that an early abort really stops buffer writes and suppresses the CRC flags. A design that kept writing or that flagged both CRC outcomes would show unexpected scoreboard writes or wrong status bits. The bench also exercises the 240-byte boundary, gapped input bits, masked interrupts and partial status clears.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SYNC = 2'd1,
        ST_PAY  = 2'd2
    } rxdf_state_e;

    typedef enum logic [1:0] {
        CODE_RAW   = 2'd0,
        CODE_MANCH = 2'd1,
        CODE_WHITE = 2'd2,
        CODE_RSVD  = 2'd3
    } rxdf_code_e;

    localparam int EV_PRE     = 0;
    localparam int EV_SYNC    = 1;
    localparam int EV_ADDR    = 2;
    localparam int EV_CRC_OK  = 3;
    localparam int EV_CRC_BAD = 4;
    localparam int EV_N       = 5;

    localparam logic [8:0]  WHITE_SEED = 9'h1FF;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/rxdf_decode.sv
module rxdf_decode
    import rxdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       chip_vld,
    input  logic       chip,
    input  logic [1:0] mode,
    output logic       dbit_vld,
    output logic       dbit,
    output logic       code_err
);
    typedef struct packed {
        logic       half;
        logic       first;
        logic [8:0] lfsr;
    } dec_t;

    dec_t q, d;

    always_comb begin
        d        = q;
        dbit_vld = 1'b0;
        dbit     = chip;
        code_err = 1'b0;
        if (start) begin
            d.half = 1'b0;
            d.lfsr = WHITE_SEED;
        end else if (chip_vld) begin
            unique case (rxdf_code_e'(mode))
                CODE_MANCH: begin
                    if (!q.half) begin
                        d.half  = 1'b1;
                        d.first = chip;
                    end else begin
                        d.half = 1'b0;
                        if (q.first == chip) begin
                            code_err = 1'b1;
                        end else begin
                            dbit_vld = 1'b1;
                            dbit     = q.first;
                        end
                    end
                end
                CODE_WHITE: begin
                    dbit_vld = 1'b1;
                    dbit     = chip ^ q.lfsr[0];
                    d.lfsr   = {q.lfsr[0] ^ q.lfsr[5], q.lfsr[8:1]};
                end
                default: begin
                    dbit_vld = 1'b1;
                    dbit     = chip;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{half: 1'b0, first: 1'b0, lfsr: WHITE_SEED};
        else        q <= d;
    end

endmodule

// File: rtl/rxdf_crc.sv
module rxdf_crc
    import rxdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic din,
    output logic zero_next
);
    logic [15:0] crc_q, crc_d, crc_nx;

    always_comb begin
        crc_nx = crc16_step(crc_q, din);
        crc_d  = crc_q;
        if (clr)       crc_d = CRC_INIT;
        else if (step) crc_d = crc_nx;
    end

    assign zero_next = (crc_nx == 16'h0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/rxdf_deframer.sv
module rxdf_deframer
    import rxdf_pkg::*;
#(
    parameter int SYNC_W  = 16,
    parameter int MAX_LEN = 240,
    parameter int PRE_MIN = 8,
    parameter int PRE_MAX = 32,
    parameter int TOL_W   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bit_vld,
    input  logic                               bit_in,
    input  logic [$clog2(PRE_MAX+1)-1:0]       cfg_pre_len,
    input  logic [SYNC_W-1:0]                  cfg_sync,
    input  logic [TOL_W-1:0]                   cfg_sync_tol,
    input  logic [1:0]                         cfg_code,
    input  logic [7:0]                         cfg_addr,
    input  logic [EV_N-1:0]                    irq_en,
    input  logic                               st_clr,
    input  logic [EV_N-1:0]                    st_clr_mask,
    output logic                               buf_we,
    output logic [$clog2(MAX_LEN+1)-1:0]       buf_addr,
    output logic [7:0]                         buf_data,
    output logic [EV_N-1:0]                    irq_status,
    output logic                               irq
);
    localparam int RUN_W  = $clog2(PRE_MAX + 1);
    localparam int ADDR_W = $clog2(MAX_LEN + 1);
    localparam int CNT_W  = $clog2(MAX_LEN + 3);
    localparam int ERR_W  = $clog2(SYNC_W + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PRE_MAX);

    typedef struct packed {
        rxdf_state_e       state;
        logic [SYNC_W-1:0] sh;
        logic [RUN_W-1:0]  run;
        logic [7:0]        byte_sh;
        logic [2:0]        bitn;
        logic [CNT_W-1:0]  bcnt;
        logic [CNT_W-1:0]  len;
        logic [EV_N-1:0]   status;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
    } ctl_t;

    ctl_t q, d;

    logic              dec_start, chip_vld, dbit_vld, dbit, code_err;
    logic              crc_clr, crc_step, crc_zero;
    logic [EV_N-1:0]   ev;
    logic [RUN_W-1:0]  eff_len;
    logic [SYNC_W-1:0] win;
    logic [ERR_W-1:0]  sync_err;
    logic [7:0]        byte_nx;
    logic              wr;

    rxdf_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dec_start),
        .chip_vld (chip_vld),
        .chip     (bit_in),
        .mode     (cfg_code),
        .dbit_vld (dbit_vld),
        .dbit     (dbit),
        .code_err (code_err)
    );

    rxdf_crc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (crc_clr),
        .step      (crc_step),
        .din       (dbit),
        .zero_next (crc_zero)
    );

    always_comb begin
        if (cfg_pre_len < RUN_W'(PRE_MIN))      eff_len = RUN_W'(PRE_MIN);
        else if (cfg_pre_len > RUN_W'(PRE_MAX)) eff_len = RUN_W'(PRE_MAX);
        else                                    eff_len = cfg_pre_len;
        win      = {q.sh[SYNC_W-2:0], bit_in};
        sync_err = ERR_W'($countones(win ^ cfg_sync));
        byte_nx  = {q.byte_sh[6:0], dbit};
    end

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        ev        = '0;
        wr        = 1'b0;
        dec_start = 1'b0;
        chip_vld  = 1'b0;
        crc_clr   = 1'b0;
        crc_step  = 1'b0;
        if (bit_vld) d.sh = win;
        unique case (q.state)
            ST_HUNT: begin
                if (bit_vld) begin
                    if (bit_in != q.sh[0])
                        d.run = (q.run == RUN_MAX) ? q.run : q.run + 1'b1;
                    else
                        d.run = RUN_W'(1);
                    if (d.run >= eff_len) begin
                        ev[EV_PRE] = 1'b1;
                        d.state    = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                if (bit_vld && sync_err <= ERR_W'(cfg_sync_tol)) begin
                    ev[EV_SYNC] = 1'b1;
                    d.state     = ST_PAY;
                    dec_start   = 1'b1;
                    crc_clr     = 1'b1;
                    d.bitn      = '0;
                    d.bcnt      = '0;
                end
            end
            ST_PAY: begin
                chip_vld = bit_vld;
                crc_step = dbit_vld;
                if (code_err) begin
                    d.state = ST_HUNT;
                end else if (dbit_vld) begin
                    d.byte_sh = byte_nx;
                    d.bitn    = q.bitn + 3'd1;
                    if (q.bitn == 3'd7) begin
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == '0) begin
                            if (byte_nx == 8'd0 || int'(byte_nx) > MAX_LEN) begin
                                d.state = ST_HUNT;
                            end else begin
                                d.len = CNT_W'(byte_nx);
                                wr    = 1'b1;
                            end
                        end else if (q.bcnt == CNT_W'(1)) begin
                            wr = 1'b1;
                            if (byte_nx == cfg_addr) ev[EV_ADDR] = 1'b1;
                            else                     d.state = ST_HUNT;
                        end else if (q.bcnt <= q.len) begin
                            wr = 1'b1;
                        end else if (q.bcnt == q.len + CNT_W'(2)) begin
                            ev[EV_CRC_OK]  = crc_zero;
                            ev[EV_CRC_BAD] = !crc_zero;
                            d.state        = ST_HUNT;
                        end
                    end
                end
            end
            default: d.state = ST_HUNT;
        endcase
        if (wr) begin
            d.we    = 1'b1;
            d.waddr = ADDR_W'(q.bcnt);
            d.wdata = byte_nx;
        end
        if (d.state == ST_HUNT && q.state != ST_HUNT) d.run = '0;
        d.status = (q.status & ~(st_clr ? st_clr_mask : '0)) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_HUNT, default: '0};
        else        q <= d;
    end

    assign buf_we     = q.we;
    assign buf_addr   = q.waddr;
    assign buf_data   = q.wdata;
    assign irq_status = q.status;
    assign irq        = |(q.status & irq_en);

    // R5: no write ever lands past the largest legal frame
    a_r5_wr_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (int'(buf_addr) <= MAX_LEN));

    // R6: buffer writes only come out of payload processing
    a_r6_write_only_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> ($past(q.state) == ST_PAY));

    // R8: without a clear, no status bit drops
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !st_clr |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

    // R1: sync search is entered only with the preamble event recorded
    a_r1_pre_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SYNC && $past(q.state) == ST_HUNT) |-> irq_status[EV_PRE]);

    // R2: payload is entered only with the sync event recorded
    a_r2_sync_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PAY && $past(q.state) != ST_PAY) |-> irq_status[EV_SYNC]);

    // R4: a coding violation drops back to hunting with no write
    a_r4_err_returns_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PAY && code_err) |=> (q.state == ST_HUNT && !buf_we));

endmodule

// File: tb/rxdf_deframer_tb.sv
module rxdf_deframer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [5:0]  cfg_pre_len = 6'd16;
    logic [15:0] cfg_sync = 16'h2DD4;
    logic [1:0]  cfg_sync_tol = 2'd0;
    logic [1:0]  cfg_code = 2'd0;
    logic [7:0]  cfg_addr = 8'h5A;
    logic [4:0]  irq_en = 5'h1F;
    logic        st_clr = 1'b0;
    logic [4:0]  st_clr_mask = 5'h00;
    logic        buf_we;
    logic [7:0]  buf_addr;
    logic [7:0]  buf_data;
    logic [4:0]  irq_status;
    logic        irq;

    int          n_chk = 0;
    int          n_bad = 0;
    logic        gap_on = 1'b0;
    logic [8:0]  wl;
    logic [15:0] tcrc;
    logic [15:0] exp_q[$];

    localparam logic [15:0] SYNCW = 16'h2DD4;

    always #2 clk = ~clk;

    rxdf_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .cfg_pre_len(cfg_pre_len), .cfg_sync(cfg_sync), .cfg_sync_tol(cfg_sync_tol),
        .cfg_code(cfg_code), .cfg_addr(cfg_addr), .irq_en(irq_en),
        .st_clr(st_clr), .st_clr_mask(st_clr_mask), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_data(buf_data), .irq_status(irq_status), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every buffer write must match the next expected item
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected buffer write", {buf_addr, buf_data}, 16'hxxxx);
            end else begin
                check("R5 R6 buffer write", {buf_addr, buf_data}, exp_q.pop_front());
            end
        end
    end

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic b);
        return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [7:0] dat(input int i, input logic [7:0] a);
        return 8'((i * 29 + 7) & 255) ^ a;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        if (gap_on) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    task automatic pbit(input logic b);
        case (cfg_code)
            2'd1: begin send_bit(b); send_bit(~b); end
            2'd2: begin
                send_bit(b ^ wl[0]);
                wl = {wl[0] ^ wl[5], wl[8:1]};
            end
            default: send_bit(b);
        endcase
    endtask

    task automatic pbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            tcrc = bcrc(tcrc, v[i]);
            pbit(v[i]);
        end
    endtask

    task automatic pre_sync(input int pl, input logic [15:0] sw);
        send_bit(1'b1);
        send_bit(1'b1);
        for (int i = 0; i < pl; i++) send_bit((i % 2) == 0);
        for (int i = 15; i >= 0; i--) send_bit(sw[i]);
        tcrc = 16'hFFFF;
        wl   = 9'h1FF;
    endtask

    task automatic frame(input int pl, input logic [15:0] sw, input logic sync_ok,
                         input int lenb, input logic [7:0] adr, input logic bad_crc);
        logic [15:0] c;
        pre_sync(pl, sw);
        if (sync_ok) begin
            if (lenb < 1 || lenb > 240) begin
                pbyte(8'(lenb)); pbyte(8'h00); pbyte(8'hFF);
            end else begin
                exp_q.push_back({8'd0, 8'(lenb)});
                pbyte(8'(lenb));
                exp_q.push_back({8'd1, adr});
                pbyte(adr);
                if (adr != cfg_addr) begin
                    pbyte(8'h00); pbyte(8'hFF);
                end else begin
                    for (int i = 2; i <= lenb; i++) begin
                        exp_q.push_back({8'(i), dat(i, adr)});
                        pbyte(dat(i, adr));
                    end
                    c = tcrc ^ (bad_crc ? 16'h0001 : 16'h0000);
                    pbyte(c[15:8]);
                    pbyte(c[7:0]);
                end
            end
        end
        idle(6);
        check("R6 all expected writes seen", exp_q.size(), 0);
    endtask

    task automatic clr(input logic [4:0] m);
        @(negedge clk);
        bit_vld = 1'b0;
        st_clr = 1'b1;
        st_clr_mask = m;
        @(negedge clk);
        st_clr = 1'b0;
        st_clr_mask = 5'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 status after reset", irq_status, 5'h00);
        check("R10 irq after reset", irq, 1'b0);
        rst_n = 1'b1;
        idle(3);
        check("R10 no write after reset", buf_we, 1'b0);

        // R7: raw frame, good CRC
        frame(16, SYNCW, 1'b1, 4, 8'h5A, 1'b0);
        check("R7 raw frame status", irq_status, 5'h0F);
        check("R9 irq with enables", irq, 1'b1);
        clr(5'h1F);
        check("R8 full clear", irq_status, 5'h00);
        check("R9 irq after clear", irq, 1'b0);

        // R3 R11: Manchester with gaps between bits
        cfg_code = 2'd1;
        gap_on = 1'b1;
        frame(16, SYNCW, 1'b1, 6, 8'h5A, 1'b0);
        check("R3 R11 Manchester gapped status", irq_status, 5'h0F);
        clr(5'h1F);
        gap_on = 1'b0;

        // R3: whitening
        cfg_code = 2'd2;
        frame(16, SYNCW, 1'b1, 3, 8'h5A, 1'b0);
        check("R3 whitened status", irq_status, 5'h0F);
        clr(5'h1F);
        cfg_code = 2'd0;

        // R7: corrupted CRC, then R8 partial clear
        frame(16, SYNCW, 1'b1, 5, 8'h5A, 1'b1);
        check("R7 bad CRC status", irq_status, 5'h17);
        clr(5'h10);
        check("R8 partial clear", irq_status, 5'h07);
        clr(5'h1F);

        // R6: foreign address
        frame(16, SYNCW, 1'b1, 4, 8'h33, 1'b0);
        check("R6 address mismatch status", irq_status, 5'h03);
        clr(5'h1F);

        // R5: oversize and zero length
        frame(16, SYNCW, 1'b1, 241, 8'h5A, 1'b0);
        check("R5 length 241 status", irq_status, 5'h03);
        clr(5'h1F);
        frame(16, SYNCW, 1'b1, 0, 8'h5A, 1'b0);
        check("R5 length 0 status", irq_status, 5'h03);
        clr(5'h1F);

        // R5: maximum length accepted
        frame(16, SYNCW, 1'b1, 240, 8'h5A, 1'b0);
        check("R5 length 240 status", irq_status, 5'h0F);
        clr(5'h1F);

        // R4: Manchester violation inside the first data byte
        cfg_code = 2'd1;
        pre_sync(16, SYNCW);
        exp_q.push_back({8'd0, 8'd5});
        pbyte(8'd5);
        exp_q.push_back({8'd1, 8'h5A});
        pbyte(8'h5A);
        pbit(1'b1); pbit(1'b0); pbit(1'b1);
        send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        idle(6);
        check("R4 writes stop at violation", exp_q.size(), 0);
        check("R4 violation status", irq_status, 5'h07);
        clr(5'h1F);
        cfg_code = 2'd0;

        // R1: clamp to 8, seven alternating bits do not count
        cfg_pre_len = 6'd3;
        send_bit(1'b1); send_bit(1'b1);
        for (int i = 0; i < 7; i++) send_bit((i % 2) == 0);
        send_bit(1'b1);
        idle(4);
        check("R1 short preamble ignored", irq_status, 5'h00);
        frame(8, SYNCW, 1'b1, 2, 8'h5A, 1'b0);
        check("R1 eight-bit preamble", irq_status, 5'h0F);
        clr(5'h1F);
        cfg_pre_len = 6'd63;
        frame(32, SYNCW, 1'b1, 2, 8'h5A, 1'b0);
        check("R1 clamp to 32", irq_status, 5'h0F);
        clr(5'h1F);
        cfg_pre_len = 6'd16;

        // R9: masking
        irq_en = 5'h00;
        frame(16, SYNCW, 1'b1, 3, 8'h5A, 1'b0);
        check("R9 status recorded while masked", irq_status, 5'h0F);
        check("R9 irq masked", irq, 1'b0);
        irq_en = 5'b01000;
        @(negedge clk);
        check("R9 irq single enable", irq, 1'b1);
        irq_en = 5'b10000;
        @(negedge clk);
        check("R9 irq other enable", irq, 1'b0);
        irq_en = 5'h1F;
        clr(5'h1F);

        // R2: sync tolerance edge
        cfg_sync_tol = 2'd3;
        frame(16, SYNCW ^ 16'h0421, 1'b1, 3, 8'h5A, 1'b0);
        check("R2 three errors accepted", irq_status, 5'h0F);
        clr(5'h1F);
        cfg_sync_tol = 2'd2;
        frame(16, SYNCW ^ 16'h0421, 1'b0, 3, 8'h5A, 1'b0);
        check("R2 three errors rejected", irq_status, 5'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule